// File: doc/BRIEF.md
# Audio Master Clock Frequency Lock Monitor

This block runs on a generated audio master clock of nominally 12.288 MHz. It judges that clock against a slow reference pulse train. The reference is brought into the clock domain through a synchronizer. The block counts master-clock cycles between successive reference rising edges and compares each count with a tolerance window around the expected ratio. A select input chooses the ratio: 3072 cycles per period for a 4 kHz reference, or 1536 cycles per period for an 8 kHz reference.

The outputs are:
- a lock flag with hysteresis;
- a too-fast / too-slow classification of the latest measurement;
- the latest measured count;
- a missing-reference flag.

The block only observes the clock. It does not correct it.

Top module: `freq_lock_monitor`

## Requirements
- R1: After reset, `locked`, `too_fast`, `too_slow` and `ref_missing` are 0 and `last_count` is 0. No lock is reported before a reference rising edge has been seen.
- R2: `ref_in` passes through a two-stage synchronizer and a rising-edge detector. On each detected rising edge after the first, `last_count` takes the number of `clk` cycles since the previous detected rising edge.
- R3: With `rate_sel`=1 the acceptance window is 1532..1540 counts. With `rate_sel`=0 it is 3065..3079 counts. On each measurement, `too_fast`=1 if the count is above the window and `too_slow`=1 if it is below. Both are 0 inside the window, and they are never both 1.
- R4: `locked` goes to 1 on the fourth consecutive in-window measurement.
- R5: Once locked, a single out-of-window measurement leaves `locked` at 1. The second consecutive one clears it.
- R6: When 4096 `clk` cycles pass without a detected rising edge, `ref_missing` goes to 1 and `locked`, `too_fast` and `too_slow` clear. The next edge clears `ref_missing` without producing a measurement.
- R7: A change of `rate_sel` clears `locked`, both flags and the run history, and discards the period in progress. `last_count` keeps its value until a full period has been measured after the change.
- R8: Only rising edges are used for timing. The reference high time, whether a few cycles or half the period, does not change the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generated master clock being judged |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous reference pulse train |
| rate_sel | input | 1 | 1: 8 kHz reference (1536 ratio), 0: 4 kHz reference (3072 ratio) |
| locked | output | 1 | Frequency lock indication |
| too_fast | output | 1 | Last measurement above the window |
| too_slow | output | 1 | Last measurement below the window |
| ref_missing | output | 1 | No reference edge for the timeout span |
| last_count | output | 13 | Latest measured cycles per reference period |

## Verification
The properties assume `rate_sel` changes only between clock edges, and that `ref_in` is a clean level that the synchronizer can sample. They also assume a reference high time of at least a few master-clock cycles, so that every rising edge is seen. The stimulus drives all inputs on the falling clock edge. It keeps reference pulses at three cycles or longer, and it switches the select input only partway through a period. This exercises the discard of the partial measurement without creating glitches the assertions do not model.

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor #(
  parameter int NOM_SLOW   = 3072,
  parameter int NOM_FAST   = 1536,
  parameter int TOL_SLOW   = 7,
  parameter int TOL_FAST   = 4,
  parameter int LOCK_RUN   = 4,
  parameter int UNLOCK_RUN = 2,
  parameter int TIMEOUT    = 4096,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          rate_sel,
  output logic          locked,
  output logic          too_fast,
  output logic          too_slow,
  output logic          ref_missing,
  output logic [CW-1:0] last_count
);
  localparam int RMAX = (LOCK_RUN > UNLOCK_RUN) ? LOCK_RUN : UNLOCK_RUN;
  localparam int RW = $clog2(RMAX + 1);
  localparam logic [CW-1:0] SLOW_LO = CW'(NOM_SLOW - TOL_SLOW);
  localparam logic [CW-1:0] SLOW_HI = CW'(NOM_SLOW + TOL_SLOW);
  localparam logic [CW-1:0] FAST_LO = CW'(NOM_FAST - TOL_FAST);
  localparam logic [CW-1:0] FAST_HI = CW'(NOM_FAST + TOL_FAST);
  localparam logic [CW-1:0] TMO     = CW'(TIMEOUT);
  localparam logic [RW-1:0] LOCK_LAST = RW'(LOCK_RUN - 1);
  localparam logic [RW-1:0] DROP_LAST = RW'(UNLOCK_RUN - 1);

  logic          s1, s2, s3, sel_q, seen;
  logic [CW-1:0] cnt;
  logic [RW-1:0] good_run, bad_run;

  wire          rise     = s2 & ~s3;
  wire          sel_chg  = rate_sel ^ sel_q;
  wire          valid    = rise & seen & ~ref_missing;
  wire [CW-1:0] lo       = sel_q ? FAST_LO : SLOW_LO;
  wire [CW-1:0] hi       = sel_q ? FAST_HI : SLOW_HI;
  wire          in_win   = (cnt >= lo) && (cnt <= hi);
  wire          lock_hit = in_win && (good_run >= LOCK_LAST);
  wire          drop_hit = !in_win && (bad_run >= DROP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      sel_q <= 1'b0; seen <= 1'b0; cnt <= '0;
      good_run <= '0; bad_run <= '0;
      locked <= 1'b0; too_fast <= 1'b0; too_slow <= 1'b0;
      ref_missing <= 1'b0; last_count <= '0;
    end else begin
      s1 <= ref_in;
      s2 <= s1;
      s3 <= s2;
      sel_q <= rate_sel;
      if (sel_chg) begin
        seen <= 1'b0;
        cnt <= '0;
        good_run <= '0;
        bad_run <= '0;
        locked <= 1'b0;
        too_fast <= 1'b0;
        too_slow <= 1'b0;
      end else if (rise) begin
        seen <= 1'b1;
        ref_missing <= 1'b0;
        cnt <= CW'(1);
        if (valid) begin
          last_count <= cnt;
          too_fast <= cnt > hi;
          too_slow <= cnt < lo;
          if (in_win) begin
            bad_run <= '0;
            if (lock_hit) locked <= 1'b1;
            else good_run <= good_run + 1'b1;
          end else begin
            good_run <= '0;
            if (drop_hit) locked <= 1'b0;
            else bad_run <= bad_run + 1'b1;
          end
        end
      end else if (cnt == TMO) begin
        ref_missing <= 1'b1;
        locked <= 1'b0;
        too_fast <= 1'b0;
        too_slow <= 1'b0;
        good_run <= '0;
        bad_run <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/freq_lock_monitor_chk.sv
module freq_lock_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic rate_sel,
  input logic locked,
  input logic too_fast,
  input logic too_slow,
  input logic ref_missing
);
  // R3
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(too_fast && too_slow));
  // R6
  miss_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_missing |-> !locked);
  // R6
  miss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_missing) |-> (!too_fast && !too_slow));
  // R7
  sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != $past(rate_sel)) |=> !locked);
  // R4
  lock_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (!too_fast && !too_slow));
endmodule

bind freq_lock_monitor freq_lock_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .locked(locked),
  .too_fast(too_fast), .too_slow(too_slow), .ref_missing(ref_missing)
);

// File: tb/freq_lock_monitor_test.sv
`timescale 1ns/1ps
module freq_lock_monitor_test;
  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, rate_sel = 1'b0;
  logic locked, too_fast, too_slow, ref_missing;
  logic [12:0] last_count;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  freq_lock_monitor uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rate_sel(rate_sel),
    .locked(locked), .too_fast(too_fast), .too_slow(too_slow),
    .ref_missing(ref_missing), .last_count(last_count)
  );

  // behavioural model
  int sq[$] = '{0, 0, 0};
  int m_sel, m_seen, m_cnt, m_good, m_bad, m_lock, m_fast, m_slow, m_miss, m_last;
  always @(posedge clk) begin
    if (!rst_n) begin
      sq = '{0, 0, 0};
      m_sel = 0; m_seen = 0; m_cnt = 0; m_good = 0; m_bad = 0;
      m_lock = 0; m_fast = 0; m_slow = 0; m_miss = 0; m_last = 0;
    end else begin
      bit edge_now, chg;
      int lo, hi;
      edge_now = (sq[1] == 1) && (sq[2] == 0);
      chg = (int'(rate_sel) != m_sel);
      lo = m_sel ? 1532 : 3065;
      hi = m_sel ? 1540 : 3079;
      if (chg) begin
        m_seen = 0; m_cnt = 0; m_good = 0; m_bad = 0;
        m_lock = 0; m_fast = 0; m_slow = 0;
      end else if (edge_now) begin
        if (m_seen && !m_miss) begin
          m_last = m_cnt;
          m_fast = m_cnt > hi;
          m_slow = m_cnt < lo;
          if (m_cnt >= lo && m_cnt <= hi) begin
            m_bad = 0; m_good++;
            if (m_good >= 4) m_lock = 1;
          end else begin
            m_good = 0; m_bad++;
            if (m_bad >= 2) m_lock = 0;
          end
        end
        m_seen = 1; m_miss = 0; m_cnt = 1;
      end else if (m_cnt == 4096) begin
        m_miss = 1; m_lock = 0; m_fast = 0; m_slow = 0; m_good = 0; m_bad = 0;
      end else m_cnt++;
      sq.push_front(int'(ref_in));
      void'(sq.pop_back());
      m_sel = int'(rate_sel);
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (int'(locked) != m_lock) begin
      failures++; $display("FAIL R4/R5 locked act=%0d exp=%0d", locked, m_lock);
    end
    if (int'(too_fast) != m_fast || int'(too_slow) != m_slow) begin
      failures++; $display("FAIL R3 flags act=%0d%0d exp=%0d%0d", too_fast, too_slow, m_fast, m_slow);
    end
    if (int'(last_count) != m_last) begin
      failures++; $display("FAIL R2 last_count act=%0d exp=%0d", last_count, m_last);
    end
    if (int'(ref_missing) != m_miss) begin
      failures++; $display("FAIL R6 ref_missing act=%0d exp=%0d", ref_missing, m_miss);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic period(input int p, input int h);
    ref_in = 1'b1;
    repeat (h) @(negedge clk);
    ref_in = 1'b0;
    repeat (p - h) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!locked && !too_fast && !too_slow && !ref_missing, "R1 reset flags", locked, 0);
    chk(last_count == 0, "R1 reset count", int'(last_count), 0);
    rate_sel = 1'b1;
    repeat (3) @(negedge clk);
    period(1536, 3);
    chk(!locked, "R1 no lock after first edge", locked, 0);
    for (int i = 0; i < 5; i++) period(1536, 3);
    chk(locked == 1, "R4 locked after four in-window", locked, 1);
    chk(last_count == 1536, "R2 count 1536", int'(last_count), 1536);
    period(1540, 770);
    period(1532, 3);
    chk(last_count == 1540 && !too_fast, "R8 long high, R3 upper edge", int'(last_count), 1540);
    period(1541, 3);
    chk(last_count == 1532 && !too_slow, "R3 lower edge 1532", int'(last_count), 1532);
    period(1541, 3);
    chk(too_fast == 1 && locked == 1, "R5 single miss keeps lock", locked, 1);
    period(1531, 3);
    chk(locked == 0, "R5 second miss drops lock", locked, 0);
    period(1536, 3);
    chk(too_slow == 1 && last_count == 1531, "R3 too_slow 1531", int'(too_slow), 1);
    period(1000, 3);
    rate_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk(!locked && !too_fast && !too_slow, "R7 select change clears", locked, 0);
    period(3072, 3);
    chk(last_count == 1536, "R7 partial discarded", int'(last_count), 1536);
    for (int i = 0; i < 5; i++) period(3072, 1536);
    chk(locked == 1 && last_count == 3072, "R4 lock in 4 kHz mode", locked, 1);
    period(3079, 3);
    period(3065, 3);
    chk(last_count == 3079 && !too_fast, "R3 upper edge 3079", int'(last_count), 3079);
    period(3080, 3);
    chk(last_count == 3065 && !too_slow, "R3 lower edge 3065", int'(last_count), 3065);
    period(3064, 3);
    chk(too_fast == 1 && locked == 1, "R3 too_fast 3080", int'(too_fast), 1);
    period(3072, 3);
    chk(too_slow == 1 && locked == 0, "R5 drop in 4 kHz mode", locked, 0);
    repeat (4200) @(negedge clk);
    chk(ref_missing == 1 && !locked, "R6 missing reference", int'(ref_missing), 1);
    period(3072, 3);
    chk(ref_missing == 0 && last_count == 3064, "R6 edge clears, no measurement", int'(last_count), 3064);
    period(3072, 3);
    chk(last_count == 3072, "R6 measurement resumes", int'(last_count), 3072);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule